// File: doc/BRIEF.md
# Exhaustive Adder Self-Test Controller

This block is an on-chip tester for a two-operand adder. After reset it waits. A rising edge on `go` starts the sweep. The tester then drives every operand pair into the adder under test, one pair per clock. The pair is a single counter of `2*OPW` bits: operand A is the upper half and operand B is the lower half. The counter starts at zero and counts upward.

For each pair, the tester builds its own reference result of `OPW+1` bits (carry-out plus sum). It compares that result with what the adder returns. When the adder is registered, the reference is delayed by `LAT` cycles so both sides line up.

On the first wrong result the sweep stops and `err` goes high. The failing pair is frozen on `op_a`/`op_b`, so it can be read from a display. The display output shows either the operand pair or the adder's returned sum, chosen by `sel_sum`. Each later `go` edge resumes from the vector after the failing one. Once the all-ones vector has been checked, `running` drops and `done` rises. For 16-bit operands at 27 MHz, a clean sweep of about four billion vectors takes close to 160 seconds.

Top module: `adt_sweep_tester`

## Requirements
- R1: After reset, `err`, `running` and `done` are low, the operand outputs are zero, and the block waits for `go`.
- R2: One clock after a rising edge of `go` in the waiting state, `running` is high and the first vector A=0, B=0 is on the operand outputs.
- R3: The reference result is the `OPW+1`-bit sum {carry, sum} of A and B. Any difference from `dut_sum` stops the sweep: `err` high and `running` low from the next clock.
- R4: While stopped on an error, `op_a` and `op_b` hold the pair that produced the wrong result, unchanged from cycle to cycle.
- R5: Only a rising edge of `go` acts. A `go` held high for many cycles resumes the sweep exactly once. The sweep restarts at the vector after the failing one.
- R6: The vector is {A, B}, with B in the low `OPW` bits, and it increments by one per clock. The sweep ends after the vector with every bit set has been checked. Then `done` is high, `running` is low, and both stay that way until reset.
- R7: A mismatch on the all-ones vector first stops with `err` high. The following `go` edge ends the sweep with `done` high.
- R8: With an adder latency `LAT` greater than zero, each returned sum is compared against the pair applied `LAT` cycles earlier. The operands shown when stopped are that pair, and vectors already issued behind it are applied again after resume.
- R9: `disp` is registered. One clock after `sel_sum` changes, it shows {A, B} when `sel_sum` is 0, or `dut_sum` zero-extended to `2*OPW` bits when `sel_sum` is 1.
- R10: A `go` edge has no effect while the sweep is running or after it has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start / resume request, rising edge acts |
| sel_sum | input | 1 | Display select: 0 operands, 1 returned sum |
| dut_sum | input | OPW+1 | Carry-out and sum from the adder under test |
| op_a | output | OPW | Operand A to the adder |
| op_b | output | OPW | Operand B to the adder |
| err | output | 1 | Stopped on a mismatch |
| running | output | 1 | Sweep in progress |
| done | output | 1 | Whole operand space covered |
| disp | output | 2*OPW | Value for the display |

## Verification
Two events can fall in the same cycle: a detected mismatch and the end of the sweep. The bench provokes this by injecting a fault on the all-ones vector. It then expects a stop with `err` before `done`, and `done` only after the next `go` edge. Resume and a fresh failure can also coincide. Two adjacent faulty vectors are placed so that the sweep fails again while `go` is still held high. The bench judges that the tester stops at the second vector and does not step past it. Both cases are run with a combinational adder and with a two-cycle registered adder. A scoreboard queue lists the expected failing pairs in order.

// File: rtl/adt_pkg.sv
package adt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_HALT  = 3'd3,
    ST_DONE  = 3'd4
  } tst_state_e;

endpackage

// File: rtl/adt_go_edge.sv
module adt_go_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign pulse = lvl & ~lvl_q;

  // R5: a level held high yields a single-cycle request
  assert_one_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/adt_ref_delay.sv
module adt_ref_delay #(
  parameter int VW  = 32,
  parameter int LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_v,
  input  logic [VW-1:0] in_vec,
  output logic          out_v,
  output logic [VW-1:0] out_vec,
  output logic          busy
);

  logic [LAT-1:0] v_q;
  logic [VW-1:0]  vec_q [LAT];

  genvar gi;
  generate
    for (gi = 0; gi < LAT; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst || flush) v_q[0] <= 1'b0;
          else              v_q[0] <= in_v;
          vec_q[0] <= in_vec;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst || flush) v_q[gi] <= 1'b0;
          else              v_q[gi] <= v_q[gi-1];
          vec_q[gi] <= vec_q[gi-1];
        end
      end
    end
  endgenerate

  assign out_v   = v_q[LAT-1];
  assign out_vec = vec_q[LAT-1];
  assign busy    = |v_q;

  // R8: a flush kills every in-flight vector
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !busy);

endmodule

// File: rtl/adt_sum_check.sv
module adt_sum_check #(
  parameter int OPW = 16
) (
  input  logic             chk_v,
  input  logic [2*OPW-1:0] chk_vec,
  input  logic [OPW:0]     dut_sum,
  output logic             mis
);

  logic [OPW:0] ref_sum;

  always_comb begin
    ref_sum = {1'b0, chk_vec[2*OPW-1:OPW]} + {1'b0, chk_vec[OPW-1:0]};
    mis     = chk_v && (dut_sum != ref_sum);
  end

endmodule

// File: rtl/adt_sweep_tester.sv
module adt_sweep_tester
  import adt_pkg::*;
#(
  parameter int OPW = 16,
  parameter int LAT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             sel_sum,
  input  logic [OPW:0]     dut_sum,
  output logic [OPW-1:0]   op_a,
  output logic [OPW-1:0]   op_b,
  output logic             err,
  output logic             running,
  output logic             done,
  output logic [2*OPW-1:0] disp
);

  localparam int          VW   = 2 * OPW;
  localparam logic [VW-1:0] LAST = {VW{1'b1}};

  tst_state_e    st_q, st_n;
  logic [VW-1:0] vec_q, vec_n;
  logic          err_q, run_q, done_q;
  logic [VW-1:0] disp_q;

  logic          go_p;
  logic          app_v;
  logic          chk_v;
  logic [VW-1:0] chk_vec;
  logic          busy;
  logic          mis;

  adt_go_edge u_go (
    .clk   (clk),
    .rst   (rst),
    .lvl   (go),
    .pulse (go_p)
  );

  assign app_v = (st_q == ST_RUN);

  generate
    if (LAT == 0) begin : g_comb
      assign chk_v   = app_v;
      assign chk_vec = vec_q;
      assign busy    = 1'b0;
    end else begin : g_pipe
      adt_ref_delay #(.VW(VW), .LAT(LAT)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .flush   (mis),
        .in_v    (app_v),
        .in_vec  (vec_q),
        .out_v   (chk_v),
        .out_vec (chk_vec),
        .busy    (busy)
      );
    end
  endgenerate

  adt_sum_check #(.OPW(OPW)) u_chk (
    .chk_v   (chk_v),
    .chk_vec (chk_vec),
    .dut_sum (dut_sum),
    .mis     (mis)
  );

  always_comb begin
    st_n  = st_q;
    vec_n = vec_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go_p) begin
          st_n  = ST_RUN;
          vec_n = '0;
        end
      end
      ST_RUN: begin
        if (mis) begin
          st_n  = ST_HALT;
          vec_n = chk_vec;
        end else if (vec_q == LAST) begin
          st_n = ST_DRAIN;
        end else begin
          vec_n = vec_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (mis) begin
          st_n  = ST_HALT;
          vec_n = chk_vec;
        end else if (!busy) begin
          st_n = ST_DONE;
        end
      end
      ST_HALT: begin
        if (go_p) begin
          if (vec_q == LAST) begin
            st_n = ST_DONE;
          end else begin
            st_n  = ST_RUN;
            vec_n = vec_q + 1'b1;
          end
        end
      end
      ST_DONE: st_n = ST_DONE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      vec_q  <= '0;
      err_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      disp_q <= '0;
    end else begin
      st_q   <= st_n;
      vec_q  <= vec_n;
      err_q  <= (st_n == ST_HALT);
      run_q  <= (st_n == ST_RUN) || (st_n == ST_DRAIN);
      done_q <= (st_n == ST_DONE);
      disp_q <= sel_sum ? {{(VW-OPW-1){1'b0}}, dut_sum} : vec_q;
    end
  end

  assign op_a    = vec_q[VW-1:OPW];
  assign op_b    = vec_q[OPW-1:0];
  assign err     = err_q;
  assign running = run_q;
  assign done    = done_q;
  assign disp    = disp_q;

  // R2: a start request applies vector zero on the next cycle
  assert_start_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && go_p) |=> (running && op_a == '0 && op_b == '0));

  // R3: a detected mismatch during the sweep stops it
  assert_halt_on_mis_R3: assert property (@(posedge clk) disable iff (rst)
    (mis && (st_q == ST_RUN || st_q == ST_DRAIN)) |=> (err && !running));

  // R4: operands frozen while stopped
  assert_hold_ops_R4: assert property (@(posedge clk) disable iff (rst)
    (err && $past(err)) |-> ($stable(op_a) && $stable(op_b)));

  // R6: completion is final
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !running && !err));

  // R7: resume from a failure on the last vector ends the sweep
  assert_final_fail_R7: assert property (@(posedge clk) disable iff (rst)
    (err && op_a == {OPW{1'b1}} && op_b == {OPW{1'b1}} && go_p) |=> done);

endmodule

// File: tb/test_adt_sweep_tester.sv
`timescale 1ns/1ps
module test_adt_sweep_tester;

  localparam int W  = 4;
  localparam int VW = 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go0 = 1'b0, go1 = 1'b0, sel = 1'b0;
  logic [W-1:0]  a0, b0, a1, b1;
  logic [W:0]    sum0, sum1, pre1;
  logic          err0, run0, done0, err1, run1, done1;
  logic [VW-1:0] disp0, disp1;

  int checks = 0;
  int fails  = 0;
  int halts  = 0;
  int cur    = 0;
  logic [VW-1:0] exp_q[$];
  logic          m_prev = 1'b0;

  always #2.5 clk = ~clk;

  function automatic bit is_fault(logic [VW-1:0] v);
    return (v == 8'h00) || (v == 8'h35) || (v == 8'h36) || (v == 8'h9C) || (v == 8'hFF);
  endfunction

  function automatic logic [W:0] adder_model(logic [VW-1:0] v);
    logic [W:0] s;
    s = {1'b0, v[VW-1:W]} + {1'b0, v[W-1:0]};
    if (is_fault(v)) s = s ^ 5'd1;
    return s;
  endfunction

  always_comb sum0 = adder_model({a0, b0});
  always @(posedge clk) begin
    pre1 <= adder_model({a1, b1});
    sum1 <= pre1;
  end

  adt_sweep_tester #(.OPW(W), .LAT(0)) i_adt_sweep_tester (
    .clk(clk), .rst(rst), .go(go0), .sel_sum(sel), .dut_sum(sum0),
    .op_a(a0), .op_b(b0), .err(err0), .running(run0), .done(done0), .disp(disp0));

  adt_sweep_tester #(.OPW(W), .LAT(2)) i_adt_sweep_tester_lat (
    .clk(clk), .rst(rst), .go(go1), .sel_sum(sel), .dut_sum(sum1),
    .op_a(a1), .op_b(b1), .err(err1), .running(run1), .done(done1), .disp(disp1));

  logic [VW-1:0] m_op, m_disp;
  logic          m_err, m_run, m_done;
  assign m_op   = cur ? {a1, b1} : {a0, b0};
  assign m_disp = cur ? disp1 : disp0;
  assign m_err  = cur ? err1 : err0;
  assign m_run  = cur ? run1 : run0;
  assign m_done = cur ? done1 : done0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s dut%0d actual=%0h expected=%0h", tag, cur, act, exp);
    end
  endtask

  task automatic set_go(logic v);
    if (cur == 1) go1 = v; else go0 = v;
  endtask

  task automatic pulse_go();
    @(negedge clk); set_go(1'b1);
    @(negedge clk); set_go(1'b0);
  endtask

  // monitor: each new stop is compared with the scoreboard head
  always @(negedge clk) begin
    if (m_err && !m_prev) begin
      halts++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 dut%0d unexpected stop actual=%0h expected=none", cur, m_op);
      end else begin
        logic [VW-1:0] e;
        e = exp_q.pop_front();
        if (m_op !== e) begin
          fails++;
          $display("FAIL %s stop vector actual=%0h expected=%0h", cur ? "R8" : "R3", m_op, e);
        end
      end
    end
    m_prev = m_err;
  end

  task automatic sweep();
    int seen;
    logic [VW-1:0] v;
    // driver: expected failing pairs in sweep order
    exp_q = {};
    for (int i = 0; i < (1 << VW); i++) if (is_fault(i[VW-1:0])) exp_q.push_back(i[VW-1:0]);
    seen = halts;
    pulse_go();
    chk("R2 running", {31'd0, m_run}, 32'd1);
    chk("R2 first vector", {24'd0, m_op}, 32'd0);
    forever begin
      wait (halts != seen || m_done);
      @(negedge clk);
      if (m_done) break;
      v = m_op;
      repeat (3) @(negedge clk);
      chk("R4 held operands", {24'd0, m_op}, {24'd0, v});
      chk("R4 err", {31'd0, m_err}, 32'd1);
      chk("R3 running low", {31'd0, m_run}, 32'd0);
      sel = 1'b1; repeat (2) @(negedge clk);
      chk("R9 sum view", {24'd0, m_disp}, {27'd0, adder_model(v)});
      sel = 1'b0; repeat (2) @(negedge clk);
      chk("R9 operand view", {24'd0, m_disp}, {24'd0, v});
      seen = halts;
      if (v == 8'h35) begin
        @(negedge clk); set_go(1'b1);
        repeat (6) @(negedge clk);
        set_go(1'b0);
        chk("R5 single advance", {24'd0, m_op}, 32'h36);
        chk("R5 stopped", {31'd0, m_err}, 32'd1);
      end else begin
        pulse_go();
        if (v == 8'hFF) begin
          chk("R7 done after final fail", {31'd0, m_done}, 32'd1);
        end else begin
          repeat (2) @(negedge clk);
          pulse_go(); // R10: ignored while running
        end
      end
    end
    chk("R6 done", {31'd0, m_done}, 32'd1);
    chk("R6 running low", {31'd0, m_run}, 32'd0);
    chk("R6 err low", {31'd0, m_err}, 32'd0);
    chk("R6 all stops seen", exp_q.size(), 32'd0);
    pulse_go();
    repeat (3) @(negedge clk);
    chk("R10 done kept", {31'd0, m_done}, 32'd1);
    chk("R10 running stays low", {31'd0, m_run}, 32'd0);
    chk("R10 last vector kept", {24'd0, m_op}, 32'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      cur = d;
      #0;
      chk("R1 err", {31'd0, m_err}, 32'd0);
      chk("R1 running", {31'd0, m_run}, 32'd0);
      chk("R1 done", {31'd0, m_done}, 32'd0);
      chk("R1 operands", {24'd0, m_op}, 32'd0);
    end
    cur = 0;
    @(negedge clk);
    sweep();
    cur = 1;
    @(negedge clk);
    sweep();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule